// File: doc/BRIEF.md
# Order-Tagged ALU Result Hold Queue

This block holds the results of register-only arithmetic instructions until every memory-class operation issued before them has finished. Each held entry carries a destination register index, a result word and an order tag. The tag counts how many memory-class operations were still outstanding ahead of the result when the result was produced. A successful retirement of the oldest memory operation lowers every tag by one. An entry whose tag has reached zero is released to the register file.

Results arrive on up to `LANES` input lanes per cycle. Within a cycle the lanes are taken in lane order. Across cycles the tags never decrease, so zero-tag entries always sit at the oldest end of the queue. Each cycle up to `LANES` of those oldest zero-tag entries leave on the write ports. A fault reported by the memory side discards every entry that is still waiting on a memory operation, including such entries presented on the inputs in the same cycle. Entries that are already free to commit are kept. A free-slot count lets the issue side avoid overrunning the queue.

Top module: `alu_wb_queue`

## Requirements
- R1: While reset is asserted and immediately after it, no write port is enabled and `free_cnt` equals `DEPTH`.
- R2: An entry captured with tag 0 appears on a write port in the next cycle (unless older zero-tag entries fill all ports) and carries the captured register index and data.
- R3: `free_cnt` equals `DEPTH` minus the number of held entries. The issue side never presents more valid lanes than `free_cnt`.
- R4: A cycle with `mem_ok` high and `mem_fault` low lowers the tag of every held entry by one, saturating at 0. It also lowers the tag of every input captured in that cycle.
- R5: Each cycle up to `LANES` of the oldest held entries with tag 0 commit. The oldest goes on port 0, the next on port 1, and so on. An entry with a nonzero tag never commits.
- R6: An input lane whose register index is 0 is discarded and takes no slot.
- R7: When `mem_fault` is high, all held entries with a nonzero tag and all inputs with a nonzero tag are discarded in that cycle. Zero-tag entries and inputs are kept and commit later as usual.
- R8: When two entries committing in one cycle target the same register, only the younger one (the higher port) has its write enable set.
- R9: When `mem_ok` and `mem_fault` are both high, the fault takes precedence and no tag is lowered.
- R10: Valid lanes are captured in lane order, and invalid lanes leave no gap. Tags of valid lanes do not decrease with lane index or over time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | LANES | Per-lane result valid |
| in_rd | input | LANES*5 | Per-lane destination register index |
| in_data | input | LANES*32 | Per-lane result data |
| in_tag | input | LANES*3 | Per-lane order tag |
| mem_ok | input | 1 | Oldest memory operation retired without error |
| mem_fault | input | 1 | Memory operation faulted; discard pending entries |
| rf_we | output | LANES | Register-file write enables |
| rf_rd | output | LANES*5 | Register-file write indices |
| rf_data | output | LANES*32 | Register-file write data |
| free_cnt | output | $clog2(DEPTH+1) | Number of empty slots |

## Verification
Tag lowering on a memory retirement and discarding on a fault can both be requested in the same cycle. They can also coincide with new tagged inputs. The bench provokes this with a directed cycle that raises `mem_ok` and `mem_fault` together while a tag-1 result arrives. A random phase then drives both pulses at high rates. The result is judged one cycle later at the ports: the tag-1 input must never be written, and surviving entries must commit exactly when a queue model says their tags are zero.

// File: rtl/wbq_pkg.sv
package wbq_pkg;
  localparam int RW = 5;   // register index width
  localparam int XW = 32;  // data width
  localparam int OW = 3;   // order tag width

  typedef struct packed {
    logic [RW-1:0] rd;
    logic [XW-1:0] data;
    logic [OW-1:0] ord;
  } wbq_ent_t;
endpackage

// File: rtl/wbq_accept.sv
module wbq_accept
  import wbq_pkg::*;
#(
  parameter int LANES = 2,
  localparam int LW = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0]         in_vld,
  input  logic [LANES-1:0][RW-1:0] in_rd,
  input  logic [LANES-1:0][OW-1:0] in_tag,
  input  logic                     flush,
  output logic [LANES-1:0]         acc,
  output logic [LW-1:0]            off [LANES],
  output logic [LW-1:0]            nacc
);
  logic [LW-1:0] run;

  always_comb begin
    run = '0;
    for (int i = 0; i < LANES; i++) begin
      off[i] = run;
      acc[i] = in_vld[i] && (in_rd[i] != '0) && !(flush && (in_tag[i] != '0));
      run    = run + LW'(acc[i]);
    end
    nacc = run;
  end
endmodule

// File: rtl/wbq_slots.sv
module wbq_slots
  import wbq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LANES = 2,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             dec,
  input  logic [LANES-1:0] lane_we,
  input  logic [AW-1:0]    lane_idx [LANES],
  input  wbq_ent_t         lane_ent [LANES],
  output wbq_ent_t         ent      [DEPTH]
);
  wbq_ent_t ent_q [DEPTH];
  wbq_ent_t ent_d [DEPTH];

  always_comb begin
    for (int k = 0; k < DEPTH; k++) begin
      ent_d[k] = ent_q[k];
      if (dec && (ent_q[k].ord != '0)) ent_d[k].ord = ent_q[k].ord - OW'(1);
    end
    for (int i = 0; i < LANES; i++) begin
      if (lane_we[i]) ent_d[lane_idx[i]] = lane_ent[i];
    end
  end

  // payload storage carries no reset; validity lives in the head/count registers
  always_ff @(posedge clk) begin
    for (int k = 0; k < DEPTH; k++) ent_q[k] <= ent_d[k];
  end

  assign ent = ent_q;
endmodule

// File: rtl/wbq_commit.sv
module wbq_commit
  import wbq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LANES = 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  wbq_ent_t                 head_ent [LANES],
  input  logic [CW-1:0]            ncommit,
  output logic [LANES-1:0]         we,
  output logic [LANES-1:0][RW-1:0] rd,
  output logic [LANES-1:0][XW-1:0] data
);
  logic [LANES-1:0] live;

  always_comb begin
    for (int p = 0; p < LANES; p++) begin
      live[p] = CW'(p) < ncommit;
      rd[p]   = head_ent[p].rd;
      data[p] = head_ent[p].data;
    end
    for (int p = 0; p < LANES; p++) begin
      we[p] = live[p];
      for (int q = p + 1; q < LANES; q++) begin
        if (live[q] && (head_ent[q].rd == head_ent[p].rd)) we[p] = 1'b0;
      end
    end
  end

  for (genvar p = 0; p < LANES; p++) begin : g_port_chk
    assert_commit_order0_R5: assert property (@(posedge clk) disable iff (!rst_n)
      we[p] |-> (head_ent[p].ord == '0));
    assert_no_x0_R6: assert property (@(posedge clk) disable iff (!rst_n)
      we[p] |-> (rd[p] != '0));
    for (genvar q = p + 1; q < LANES; q++) begin : g_pair
      assert_youngest_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we[p] && we[q]) |-> (rd[p] != rd[q]));
    end
  end
endmodule

// File: rtl/alu_wb_queue.sv
module alu_wb_queue
  import wbq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LANES = 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LANES-1:0]         in_vld,
  input  logic [LANES-1:0][RW-1:0] in_rd,
  input  logic [LANES-1:0][XW-1:0] in_data,
  input  logic [LANES-1:0][OW-1:0] in_tag,
  input  logic                     mem_ok,
  input  logic                     mem_fault,
  output logic [LANES-1:0]         rf_we,
  output logic [LANES-1:0][RW-1:0] rf_rd,
  output logic [LANES-1:0][XW-1:0] rf_data,
  output logic [CW-1:0]            free_cnt
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(LANES + 1);

  logic [AW-1:0]    head_q, head_d, base;
  logic [CW-1:0]    cnt_q, cnt_d, nz0, ncommit;
  logic             run, dec;
  logic [AW-1:0]    sidx;
  logic [LANES-1:0] acc;
  logic [LW-1:0]    off [LANES];
  logic [LW-1:0]    nacc;
  logic [AW-1:0]    lane_idx [LANES];
  wbq_ent_t         lane_ent [LANES];
  wbq_ent_t         slot_ent [DEPTH];
  wbq_ent_t         head_ent [LANES];

  assign dec = mem_ok && !mem_fault;

  wbq_accept #(.LANES(LANES)) u_accept (
    .in_vld(in_vld), .in_rd(in_rd), .in_tag(in_tag), .flush(mem_fault),
    .acc(acc), .off(off), .nacc(nacc)
  );

  // zero-tag entries form a prefix from the head
  always_comb begin
    nz0  = '0;
    run  = 1'b1;
    sidx = head_q;
    for (int k = 0; k < DEPTH; k++) begin
      sidx = head_q + AW'(k);
      if (run && (CW'(k) < cnt_q) && (slot_ent[sidx].ord == '0)) nz0 = nz0 + CW'(1);
      else run = 1'b0;
    end
  end

  assign ncommit = (nz0 > CW'(LANES)) ? CW'(LANES) : nz0;

  always_comb begin
    for (int p = 0; p < LANES; p++) head_ent[p] = slot_ent[head_q + AW'(p)];
  end

  // a fault truncates the queue after the zero-tag prefix
  assign base = mem_fault ? (head_q + nz0[AW-1:0]) : (head_q + cnt_q[AW-1:0]);

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      lane_idx[i]      = base + AW'(off[i]);
      lane_ent[i].rd   = in_rd[i];
      lane_ent[i].data = in_data[i];
      lane_ent[i].ord  = (dec && (in_tag[i] != '0)) ? in_tag[i] - OW'(1) : in_tag[i];
    end
  end

  wbq_slots #(.DEPTH(DEPTH), .LANES(LANES)) u_slots (
    .clk(clk), .dec(dec), .lane_we(acc), .lane_idx(lane_idx),
    .lane_ent(lane_ent), .ent(slot_ent)
  );

  wbq_commit #(.DEPTH(DEPTH), .LANES(LANES)) u_commit (
    .clk(clk), .rst_n(rst_n), .head_ent(head_ent), .ncommit(ncommit),
    .we(rf_we), .rd(rf_rd), .data(rf_data)
  );

  always_comb begin
    head_d = head_q + ncommit[AW-1:0];
    cnt_d  = (mem_fault ? nz0 : cnt_q) - ncommit + CW'(nacc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      cnt_q  <= cnt_d;
    end
  end

  assign free_cnt = CW'(DEPTH) - cnt_q;

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(nacc) <= free_cnt);
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  assert_fault_trims_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fault |=> (int'(cnt_q) <= int'($past(nz0)) + LANES));
  assert_dec_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ok && !mem_fault && (cnt_q != '0) && (nz0 == '0)) |=> (rf_we == '0));
endmodule

// File: tb/alu_wb_queue_test.sv
module alu_wb_queue_test;
  localparam int DEPTH = 8;
  localparam int LANES = 2;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                  rst_n;
  logic [LANES-1:0]      in_vld;
  logic [LANES-1:0][4:0] in_rd;
  logic [LANES-1:0][31:0] in_data;
  logic [LANES-1:0][2:0] in_tag;
  logic                  mem_ok, mem_fault;
  logic [LANES-1:0]      rf_we;
  logic [LANES-1:0][4:0] rf_rd;
  logic [LANES-1:0][31:0] rf_data;
  logic [CW-1:0]         free_cnt;

  alu_wb_queue #(.DEPTH(DEPTH), .LANES(LANES)) uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_rd(in_rd), .in_data(in_data),
    .in_tag(in_tag), .mem_ok(mem_ok), .mem_fault(mem_fault), .rf_we(rf_we),
    .rf_rd(rf_rd), .rf_data(rf_data), .free_cnt(free_cnt)
  );

  typedef struct { int rd; int unsigned data; int ord; } m_t;
  m_t mq[$];
  int vectors = 0;
  int miscompares = 0;
  int frontier = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_outputs();
    int nc = 0;
    while (nc < LANES && nc < mq.size() && mq[nc].ord == 0) nc++;
    chk(int'(free_cnt) == DEPTH - mq.size(), "R3 free count", free_cnt, DEPTH - mq.size());
    for (int p = 0; p < LANES; p++) begin
      bit en = (p < nc);
      for (int q = p + 1; q < nc; q++) if (en && mq[q].rd == mq[p].rd) en = 0;
      chk(rf_we[p] == en, "R5/R8 write enable", rf_we[p], en);
      if (en && rf_we[p]) begin
        chk(int'(rf_rd[p]) == mq[p].rd, "R2 write index", rf_rd[p], mq[p].rd);
        chk(rf_data[p] == mq[p].data, "R2 write data", rf_data[p], mq[p].data);
      end
    end
  endtask

  // drive one cycle, advance the model, then compare after the edge
  task automatic apply(input bit v0, input int rd0, input int t0, input int unsigned d0,
                       input bit v1, input int rd1, input int t1, input int unsigned d1,
                       input bit ret, input bit fl);
    int nc = 0;
    m_t e;
    int vv[2]; int rr[2]; int tt[2]; int unsigned dd[2];
    vv[0] = v0; rr[0] = rd0; tt[0] = t0; dd[0] = d0;
    vv[1] = v1; rr[1] = rd1; tt[1] = t1; dd[1] = d1;
    for (int i = 0; i < LANES; i++) begin
      in_vld[i] = vv[i][0]; in_rd[i] = 5'(rr[i]); in_tag[i] = 3'(tt[i]); in_data[i] = dd[i];
    end
    mem_ok = ret; mem_fault = fl;
    while (nc < LANES && nc < mq.size() && mq[nc].ord == 0) nc++;
    repeat (nc) void'(mq.pop_front());
    if (fl) begin
      int keep = 0;
      while (keep < mq.size() && mq[keep].ord == 0) keep++;
      while (mq.size() > keep) void'(mq.pop_back());
    end else if (ret) begin
      foreach (mq[k]) if (mq[k].ord > 0) mq[k].ord--;
    end
    for (int i = 0; i < LANES; i++) begin
      if (vv[i] != 0 && rr[i] != 0 && !(fl && tt[i] != 0)) begin
        e.rd = rr[i]; e.data = dd[i];
        e.ord = (ret && !fl && tt[i] > 0) ? tt[i] - 1 : tt[i];
        mq.push_back(e);
      end
    end
    @(posedge clk);
    @(negedge clk);
    check_outputs();
  endtask

  task automatic rnd_step(input int pv, input int pr, input int pf, input int rdmax);
    int free = DEPTH - mq.size();
    int nv = 0;
    bit v[2]; int rr[2]; int tt[2]; int unsigned dd[2];
    bit ret, fl;
    for (int i = 0; i < LANES; i++) begin
      v[i] = (($urandom % 100) < pv) && (nv < free);
      if (v[i]) nv++;
      rr[i] = $urandom % (rdmax + 1);
      dd[i] = $urandom;
      tt[i] = frontier;
      if (($urandom % 3) == 0 && frontier < 7) frontier++;
    end
    ret = ($urandom % 100) < pr;
    fl  = ($urandom % 100) < pf;
    apply(v[0], rr[0], tt[0], dd[0], v[1], rr[1], tt[1], dd[1], ret, fl);
    if (fl) frontier = 0;
    else if (ret && frontier > 0) frontier--;
  endtask

  initial begin
    rst_n = 1'b0; in_vld = '0; in_rd = '0; in_data = '0; in_tag = '0;
    mem_ok = 1'b0; mem_fault = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(int'(free_cnt) == DEPTH, "R1 free after reset", free_cnt, DEPTH);
    chk(rf_we == '0, "R1 no write in reset", rf_we, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs();

    // R8: two same-register results in one cycle, younger must win
    apply(1, 5, 0, 32'hAAAA0001, 1, 5, 0, 32'hBBBB0002, 0, 0);
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R6: index 0 takes no slot
    apply(1, 0, 0, 32'h1234, 0, 0, 0, 0, 0, 0);
    // R10: invalid lane 0, valid lane 1
    apply(0, 3, 0, 32'h3, 1, 4, 0, 32'h4, 0, 0);
    // R9: retire and fault together drop the tag-1 input
    apply(1, 7, 1, 32'h7777, 0, 0, 0, 0, 1, 1);
    // R4: tag-1 entry released by a retirement in its capture cycle
    apply(1, 9, 1, 32'h9999, 1, 10, 2, 32'hA0A0, 1, 0);
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    apply(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    // R7: zero-tag survives fault, tag-2 entry discarded
    apply(1, 11, 0, 32'hB0B0, 1, 12, 2, 32'hC0C0, 0, 0);
    apply(1, 13, 0, 32'hD0D0, 0, 0, 0, 0, 0, 1);
    repeat (3) apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    frontier = 0;

    // R3: fill to capacity with rare retirements
    repeat (600) rnd_step(90, 5, 1, 31);
    // R5/R8: busy retirements, narrow register range
    repeat (1500) rnd_step(70, 60, 3, 3);
    // R7/R9: frequent faults mixed with retirements
    repeat (1500) rnd_step(80, 50, 30, 31);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule